// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block places each decoded CAN frame into one mailbox of a bank of message mailboxes. Every mailbox carries its own configuration: a mode, an acceptance mask and an acceptance identifier. A frame that reaches the block with its valid strobe is matched against every mailbox in receive mode in the same cycle. It is written into the lowest-numbered matching mailbox that holds no unread message. When every matching mailbox is full, the lowest matching mailbox in overwrite mode takes the frame and raises its message-ignored flag. Otherwise the frame is dropped.

Software configures the bank through a single write port. The register kind is in the top two address bits and the mailbox index is in the low bits. A transfer command takes a bit mask and re-arms a whole group of mailboxes in one write. Received contents and a status word are read through a combinational read selector. Each mailbox's ready flag also serves as its interrupt bit.

Top module: `can_rx_mbox_alloc`

## Requirements
- R1: A write with address kind 0 sets the addressed mailbox's mode from write-data bits 26:24. The modes are 0 off, 1 receive, 2 receive-with-overwrite, 3 transmit, 4 consumer and 5 producer. Only modes 1 and 2 ever take a frame, so a mailbox in any other mode never becomes ready.
- R2: A valid frame is stored in the lowest-numbered mailbox in mode 1 or 2 that accepts it and is not ready. That mailbox's ready flag is visible after the next rising clock edge.
- R3: A write with kind 2 sets the acceptance identifier. Bit 29 selects extended format and bits 28:0 hold the identifier; a standard identifier sits in bits 28:18. A mailbox accepts a frame only when the frame's format bit equals bit 29. For an extended frame, (frame_id XOR acc_id) AND mask must be zero over bits 28:0. For a standard frame, the same test is applied over bits 28:18 only.
- R4: A write with kind 1 sets the acceptance mask from bits 28:0. A mask of zero accepts every identifier of the format chosen by the identifier's bit 29.
- R5: If no accepting mailbox is free, the frame goes to the lowest-numbered accepting mailbox in mode 2. Its contents are replaced, it stays ready, and its message-ignored flag is set.
- R6: With rd_sel_i selecting a mailbox, the read outputs show the stored identifier, format bit and data. The status word holds DLC in bits 19:16, remote flag in bit 20, ready in bit 23 and message-ignored in bit 24, with all other bits zero.
- R7: A write with kind 3 clears ready and message-ignored for every mailbox whose write-data bit is set, and leaves the other mailboxes untouched.
- R8: Reading a mailbox does not clear its ready flag. mb_irq_o equals mb_rdy_o at all times.
- R9: A frame that no mailbox can take changes no ready flag, no message-ignored flag and no stored contents.
- R10: A mode write clears the ready and message-ignored flags of the addressed mailbox. It takes precedence over a frame store into that mailbox in the same cycle.
- R11: After reset every mode, mask and identifier is zero, and every ready and message-ignored flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | Decoded frame present this cycle |
| frm_ide_i | input | 1 | Frame is extended format |
| frm_id_i | input | 29 | Frame identifier, register layout (standard in 28:18) |
| frm_rtr_i | input | 1 | Remote frame |
| frm_dlc_i | input | 4 | Data length code |
| frm_data_i | input | 64 | Eight data bytes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | IDX_W+2 | {kind[1:0], mailbox index} |
| reg_wdata_i | input | 32 | Register write data |
| rd_sel_i | input | IDX_W | Mailbox selected for readout |
| rd_id_o | output | 29 | Stored identifier of selected mailbox |
| rd_ide_o | output | 1 | Stored format bit of selected mailbox |
| rd_data_o | output | 64 | Stored data of selected mailbox |
| rd_status_o | output | 32 | Status word of selected mailbox |
| mb_rdy_o | output | NUM_MB | Per-mailbox ready flags |
| mb_ign_o | output | NUM_MB | Per-mailbox message-ignored flags |
| mb_irq_o | output | NUM_MB | Per-mailbox interrupt vector |

## Verification
The bench builds the block with NUM_MB set to 6. With that bank size, one table walk gives every mode a mailbox of its own: off, receive with an exact extended filter, receive with an exact standard filter, receive with a mask-zero extended filter, transmit, and overwrite. The same walk reaches the all-full drop case and the repeated-overwrite case within a handful of frames. The small bank also makes a group re-arm across non-adjacent mailboxes easy to observe. It lets the lowest-first ordering be checked again after a partial release.

// File: rtl/can_mbox_pkg.sv
package can_mbox_pkg;
  localparam int ID_W       = 29;
  localparam int STD_LSB    = 18;
  localparam int EXT_BIT    = 29;
  localparam int MODE_LSB   = 24;
  localparam int ST_DLC_LSB = 16;
  localparam int ST_RTR_BIT = 20;
  localparam int ST_RDY_BIT = 23;
  localparam int ST_IGN_BIT = 24;
  localparam int DATA_W     = 64;

  typedef enum logic [2:0] {
    MB_OFF    = 3'd0,
    MB_RX     = 3'd1,
    MB_RX_OVR = 3'd2,
    MB_TX     = 3'd3,
    MB_CONS   = 3'd4,
    MB_PROD   = 3'd5
  } mb_mode_e;

  typedef enum logic [1:0] {
    RK_MODE = 2'd0,
    RK_MASK = 2'd1,
    RK_ID   = 2'd2,
    RK_XFER = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              rtr;
    logic [3:0]        dlc;
    logic [DATA_W-1:0] data;
  } can_frame_t;

  function automatic logic mode_is_rx(mb_mode_e m);
    return (m == MB_RX) || (m == MB_RX_OVR);
  endfunction
endpackage

// File: rtl/mbox_filter.sv
module mbox_filter
  import can_mbox_pkg::*;
(
  input  logic [ID_W-1:0] frm_id_i,
  input  logic            frm_ide_i,
  input  logic [ID_W-1:0] acc_id_i,
  input  logic            acc_ide_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            hit_o
);
  localparam int STD_W = ID_W - STD_LSB;

  logic [ID_W-1:0] care;
  logic [ID_W-1:0] diff;

  // standard frames compare only the 11-bit field
  assign care  = frm_ide_i ? mask_i : {mask_i[ID_W-1:STD_LSB], {STD_LSB{1'b0}}};
  assign diff  = (frm_id_i ^ acc_id_i) & care;
  assign hit_o = (frm_ide_i == acc_ide_i) && (diff == '0);

  logic unused_w;
  assign unused_w = ^STD_W;
endmodule

// File: rtl/mbox_pick.sv
module mbox_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

  always_comb begin
    if (any_o) begin
      AST_PICK_LOWEST: assert (((gnt_o & req_i) == gnt_o) && ((req_i & (gnt_o - 1'b1)) == '0)); // R2
    end
  end
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
  import can_mbox_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  reg_kind_e       cfg_kind_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic            rearm_i,
  input  logic            store_i,
  input  can_frame_t      frm_i,
  output mb_mode_e        mode_o,
  output logic [ID_W-1:0] mask_o,
  output logic [ID_W-1:0] acc_id_o,
  output logic            acc_ide_o,
  output logic            rdy_o,
  output logic            ign_o,
  output can_frame_t      cap_o
);
  logic mode_wr;
  assign mode_wr = cfg_we_i && (cfg_kind_i == RK_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MB_OFF;
      mask_o    <= '0;
      acc_id_o  <= '0;
      acc_ide_o <= 1'b0;
    end else if (cfg_we_i) begin
      case (cfg_kind_i)
        RK_MODE: mode_o <= mb_mode_e'(cfg_wdata_i[MODE_LSB +: 3]);
        RK_MASK: mask_o <= cfg_wdata_i[ID_W-1:0];
        RK_ID: begin
          acc_id_o  <= cfg_wdata_i[ID_W-1:0];
          acc_ide_o <= cfg_wdata_i[EXT_BIT];
        end
        default: ;
      endcase
    end
  end

  // mode write beats store beats re-arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o <= 1'b0;
      ign_o <= 1'b0;
      cap_o <= '0;
    end else if (mode_wr) begin
      rdy_o <= 1'b0;
      ign_o <= 1'b0;
    end else if (store_i) begin
      rdy_o <= 1'b1;
      ign_o <= ign_o | rdy_o;
      cap_o <= frm_i;
    end else if (rearm_i) begin
      rdy_o <= 1'b0;
      ign_o <= 1'b0;
    end
  end

  AST_RDY_RX_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> mode_is_rx(mode_o)); // R1
  AST_IGN_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ign_o) |-> ($past(rdy_o) && $past(store_i))); // R5
  AST_IGN_ONLY_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign_o |-> (mode_o == MB_RX_OVR)); // R5
endmodule

// File: rtl/can_rx_mbox_alloc.sv
module can_rx_mbox_alloc
  import can_mbox_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic              frm_ide_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              frm_rtr_i,
  input  logic [3:0]        frm_dlc_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [IDX_W-1:0]  rd_sel_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic              rd_ide_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [31:0]       rd_status_o,
  output logic [NUM_MB-1:0] mb_rdy_o,
  output logic [NUM_MB-1:0] mb_ign_o,
  output logic [NUM_MB-1:0] mb_irq_o
);
  reg_kind_e        wr_kind;
  logic [IDX_W-1:0] wr_idx;
  can_frame_t       frm;

  assign wr_kind = reg_kind_e'(reg_addr_i[IDX_W +: 2]);
  assign wr_idx  = reg_addr_i[IDX_W-1:0];
  assign frm     = '{id: frm_id_i, ide: frm_ide_i, rtr: frm_rtr_i,
                     dlc: frm_dlc_i, data: frm_data_i};

  logic [NUM_MB-1:0] hit, free_req, ovr_req, free_gnt, ovr_gnt, store;
  logic              any_free, any_ovr;
  mb_mode_e          mode   [NUM_MB];
  can_frame_t        cap    [NUM_MB];

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic [ID_W-1:0] mask, acc_id;
    logic            acc_ide, flt_hit, cfg_we, rearm;

    assign cfg_we = reg_we_i && (wr_kind != RK_XFER) && (wr_idx == IDX_W'(i));
    assign rearm  = reg_we_i && (wr_kind == RK_XFER) && reg_wdata_i[i % 32];

    mbox_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we),
      .cfg_kind_i (wr_kind),
      .cfg_wdata_i(reg_wdata_i),
      .rearm_i    (rearm),
      .store_i    (store[i]),
      .frm_i      (frm),
      .mode_o     (mode[i]),
      .mask_o     (mask),
      .acc_id_o   (acc_id),
      .acc_ide_o  (acc_ide),
      .rdy_o      (mb_rdy_o[i]),
      .ign_o      (mb_ign_o[i]),
      .cap_o      (cap[i])
    );

    mbox_filter u_flt (
      .frm_id_i (frm_id_i),
      .frm_ide_i(frm_ide_i),
      .acc_id_i (acc_id),
      .acc_ide_i(acc_ide),
      .mask_i   (mask),
      .hit_o    (flt_hit)
    );

    assign hit[i]      = frm_valid_i && flt_hit && mode_is_rx(mode[i]);
    assign free_req[i] = hit[i] && !mb_rdy_o[i];
    assign ovr_req[i]  = hit[i] && mb_rdy_o[i] && (mode[i] == MB_RX_OVR);
  end

  mbox_pick #(.N(NUM_MB)) u_pick_free (
    .req_i(free_req), .gnt_o(free_gnt), .any_o(any_free));
  mbox_pick #(.N(NUM_MB)) u_pick_ovr (
    .req_i(ovr_req), .gnt_o(ovr_gnt), .any_o(any_ovr));

  // free mailbox wins over overwriting a full one
  assign store    = any_free ? free_gnt : (any_ovr ? ovr_gnt : '0);
  assign mb_irq_o = mb_rdy_o;

  always_comb begin
    rd_id_o     = '0;
    rd_ide_o    = 1'b0;
    rd_data_o   = '0;
    rd_status_o = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (rd_sel_i == IDX_W'(i)) begin
        rd_id_o                            = cap[i].id;
        rd_ide_o                           = cap[i].ide;
        rd_data_o                          = cap[i].data;
        rd_status_o[ST_DLC_LSB +: 4]       = cap[i].dlc;
        rd_status_o[ST_RTR_BIT]            = cap[i].rtr;
        rd_status_o[ST_RDY_BIT]            = mb_rdy_o[i];
        rd_status_o[ST_IGN_BIT]            = mb_ign_o[i];
      end
    end
  end

  AST_ONE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(store)); // R2
  AST_STORE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> $stable(mb_rdy_o) || $past(reg_we_i)); // R9
  AST_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && (store == '0) && !reg_we_i) |=> ($stable(mb_rdy_o) && $stable(mb_ign_o))); // R9
endmodule

// File: tb/tb_can_rx_mbox_alloc.sv
module tb_can_rx_mbox_alloc;
  localparam int NMB = 6;
  localparam int IW  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        reg_we = 1'b0;
  logic [IW+1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [IW-1:0] rd_sel = '0;
  logic [28:0] rd_id;
  logic        rd_ide;
  logic [63:0] rd_data;
  logic [31:0] rd_status;
  logic [NMB-1:0] rdy, ign, irq;

  int n_chk = 0, n_err = 0;
  logic [NMB-1:0] exp_rdy = '0, exp_ign = '0;

  always #5 clk = ~clk;

  can_rx_mbox_alloc #(.NUM_MB(NMB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frm_valid_i(frm_valid), .frm_ide_i(frm_ide),
    .frm_id_i(frm_id), .frm_rtr_i(frm_rtr), .frm_dlc_i(frm_dlc), .frm_data_i(frm_data),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .rd_sel_i(rd_sel),
    .rd_id_o(rd_id), .rd_ide_o(rd_ide), .rd_data_o(rd_data), .rd_status_o(rd_status),
    .mb_rdy_o(rdy), .mb_ign_o(ign), .mb_irq_o(irq));

  typedef struct packed {
    logic        ide;
    logic [28:0] id;
    logic [3:0]  dlc;
    logic        rtr;
    logic [2:0]  tgt;   // 7 = dropped
    logic        ign;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 29'h01ABCDEF, 4'd8, 1'b0, 3'd1, 1'b0},
    '{1'b1, 29'h01ABCDEF, 4'd4, 1'b1, 3'd3, 1'b0},
    '{1'b1, 29'h00000055, 4'd2, 1'b0, 3'd7, 1'b0},
    '{1'b0, 29'h048C0000, 4'd1, 1'b0, 3'd2, 1'b0},
    '{1'b0, 29'h04900000, 4'd3, 1'b0, 3'd5, 1'b0},
    '{1'b0, 29'h08000000, 4'd5, 1'b0, 3'd5, 1'b1},
    '{1'b0, 29'h048C0000, 4'd6, 1'b1, 3'd5, 1'b1}
  };

  function automatic logic [63:0] dat(int k);
    return {8{8'(8'h10 + k)}};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] kind, int idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {kind, IW'(idx)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(logic ide, logic [28:0] id, logic rtr, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_id = id; frm_rtr = rtr; frm_dlc = dlc; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic chk_flags(string req);
    chk({req, " rdy"}, 64'(rdy), 64'(exp_rdy));
    chk({req, " ign"}, 64'(ign), 64'(exp_ign));
    chk("R8 irq", 64'(irq), 64'(exp_rdy));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk_flags("R11");
    rd_sel = 3'd1; #1;
    chk("R11 status", 64'(rd_status), 64'h0);
    chk("R11 id", 64'(rd_id), 64'h0);

    // configuration: kind 0 mode, 1 mask, 2 id
    wr(2'd2, 0, 32'h2000_0000);                                       // mb0 off, ext any
    wr(2'd0, 1, 32'h0100_0000); wr(2'd2, 1, 32'h2000_0000);           // mb1 rx ext any
    wr(2'd0, 2, 32'h0100_0000); wr(2'd1, 2, 32'h1FFC_0000);
    wr(2'd2, 2, 32'h048C_0000);                                       // mb2 rx std 0x123
    wr(2'd0, 3, 32'h0100_0000); wr(2'd1, 3, 32'h1FFF_FFFF);
    wr(2'd2, 3, 32'h21AB_CDEF);                                       // mb3 rx ext exact
    wr(2'd0, 4, 32'h0300_0000); wr(2'd2, 4, 32'h2000_0000);           // mb4 transmit
    wr(2'd0, 5, 32'h0200_0000);                                       // mb5 overwrite std any
    chk_flags("R1 config");

    // R2 R3 R4 R5 R9 table walk
    for (int k = 0; k < 7; k++) begin
      send(VEC[k].ide, VEC[k].id, VEC[k].rtr, VEC[k].dlc, dat(k));
      if (VEC[k].tgt != 3'd7) begin
        exp_rdy[VEC[k].tgt] = 1'b1;
        exp_ign[VEC[k].tgt] = exp_ign[VEC[k].tgt] | VEC[k].ign;
      end
      chk_flags("R2/R3/R5/R9 table");
      if (VEC[k].tgt != 3'd7) begin
        rd_sel = VEC[k].tgt; #1;
        chk("R6 id", 64'(rd_id), 64'(VEC[k].id));
        chk("R6 ide", 64'(rd_ide), 64'(VEC[k].ide));
        chk("R6 data", rd_data, dat(k));
        chk("R6 dlc", 64'(rd_status[19:16]), 64'(VEC[k].dlc));
        chk("R6 rtr", 64'(rd_status[20]), 64'(VEC[k].rtr));
      end
    end

    // R6 R8 full status words; reads leave ready set
    rd_sel = 3'd1; #1;
    chk("R6 status mb1", 64'(rd_status), 64'h0088_0000);
    chk("R8 data mb1", rd_data, dat(0));
    rd_sel = 3'd5; #1;
    chk("R6 status mb5", 64'(rd_status), 64'h0196_0000);
    @(negedge clk);
    chk_flags("R8 after read");

    // R7 group re-arm of mb1, mb2, mb5
    wr(2'd3, 0, 32'h0000_0026);
    exp_rdy = 6'b001000; exp_ign = '0;
    chk_flags("R7");

    // R2 lowest-first again after release
    send(1'b0, 29'h048C0000, 1'b0, 4'd7, 64'hA5A5);
    exp_rdy[2] = 1'b1;
    chk_flags("R2 std after rearm");
    send(1'b1, 29'h01ABCDEF, 1'b0, 4'd2, 64'h5A5A);
    exp_rdy[1] = 1'b1;
    chk_flags("R2 ext after rearm");

    // R10 mode write clears mb3
    wr(2'd0, 3, 32'h0100_0000);
    exp_rdy[3] = 1'b0;
    chk_flags("R10");

    // R1 producer mode on mb0 takes nothing; R9 drop leaves contents
    wr(2'd0, 0, 32'h0500_0000);
    send(1'b1, 29'h00000055, 1'b0, 4'd1, 64'hFFFF);
    chk_flags("R1/R9 drop");
    rd_sel = 3'd1; #1;
    chk("R9 contents kept", rd_data, 64'h5A5A);
    rd_sel = 3'd0; #1;
    chk("R1 producer idle", 64'(rd_status), 64'h0);

    // R3 re-armed exact-match mailbox takes the extended frame
    send(1'b1, 29'h01ABCDEF, 1'b1, 4'd3, 64'h1234);
    exp_rdy[3] = 1'b1;
    chk_flags("R3 exact ext");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule